// File: doc/BRIEF.md
# Saturating Wide-Dividend Sequential Divider

This block divides a 64-bit dividend by a 32-bit divisor over many clock cycles and returns a 32-bit quotient. The upper half of the dividend comes from a 32-bit high-word input, and the lower half comes from the first operand. A mode input picks signed or unsigned arithmetic. When the true quotient does not fit in 32 bits, the block clamps it to a fixed value instead of letting it wrap.

A request is accepted on a clock edge where `start_i` is high and the block is idle. The operands are captured on that edge. The block then runs one setup cycle, 64 shift-subtract iterations (one quotient bit per clock) and one completion cycle. After that it pulses `done_o` for one cycle. A zero divisor is reported on `dbz_o` in that same done cycle, and in that case the quotient and flag outputs keep their old values. Condition flags (zero, negative, overflow, carry) are produced alongside every written result, so a caller that needs the flag-setting form can use them.

Top module: `sat_div64`

## Requirements
- R1: In unsigned mode (`signed_i`=0), the dividend is `{y_i, op_a_i}` taken as an unsigned 64-bit number and the divisor is `op_b_i` taken as unsigned. If the quotient fits in 32 bits, `quot_o` equals the truncated quotient.
- R2: If `op_b_i` is 0, then `dbz_o` is 1 during the done cycle, and `quot_o` and all four flags keep the values they had before the request.
- R3: In unsigned mode, if any quotient bit above bit 31 is 1, `quot_o` is 0xFFFFFFFF.
- R4: In signed mode (`signed_i`=1), the dividend `{y_i, op_a_i}` and the divisor `op_b_i` are two's complement and the quotient rounds toward zero. A quotient above 0x7FFFFFFF gives 0x7FFFFFFF. A quotient below -2^31 gives 0x80000000. The value -2^31 itself is not clamped.
- R5: `done_o` is high for exactly one cycle, 66 clock edges after the accepting edge. `busy_o` is high from the cycle after the accepting edge up to, but not including, the done cycle.
- R6: `start_i` has no effect while `busy_o` is high. Operand inputs that change after the accepting edge do not affect the result.
- R7: With a written result, `flag_v_o` is 1 exactly when the quotient was clamped, and `flag_c_o` is 0.
- R8: With a written result, `flag_z_o` is 1 when `quot_o` is 0, and `flag_n_o` equals bit 31 of `quot_o`.
- R9: After reset, `busy_o`, `done_o`, `dbz_o`, `quot_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a divide; taken only when idle |
| signed_i | input | 1 | 1 = two's complement, 0 = unsigned |
| y_i | input | 32 | Dividend bits 63:32 |
| op_a_i | input | 32 | Dividend bits 31:0 |
| op_b_i | input | 32 | Divisor |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dbz_o | output | 1 | Zero divisor, valid with done_o |
| quot_o | output | 32 | Quotient, possibly clamped |
| flag_z_o | output | 1 | Quotient is zero |
| flag_n_o | output | 1 | Quotient bit 31 |
| flag_v_o | output | 1 | Quotient was clamped |
| flag_c_o | output | 1 | Carry, always cleared |

## Verification
Unsigned divides are run on both sides of the 32-bit limit. A high word of 4 over a divisor of 5 gives exactly 0xFFFFFFFF with no clamp, while a high word equal to the divisor must clamp. This separates the real fit test from a test of the high word alone. Signed cases cover every sign combination, for rounding toward zero. They also cover -2^31 (exact, not clamped), -2^31-1 and +2^31 (clamped), -2^31 / -1, and the most negative 64-bit dividend. A shared clamp check that ignored sign or used the wrong bound would fail on these. A zero divisor checks that the result is held. Operands changed mid-run, a repeated start during busy and a start in the same cycle as done check operand capture and back-to-back issue. Random operands fill in the rest.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIN   = 2'd3
  } sdiv_state_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } sdiv_flags_t;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   dvs_i,
  input  logic            sgn_i,
  output logic [2*DW-1:0] dvd_mag_o,
  output logic [DW-1:0]   dvs_mag_o,
  output logic            neg_o,
  output logic            zero_o
);
  logic [2*DW-1:0] dvd;
  logic            dvd_neg, dvs_neg;

  always_comb begin
    dvd       = {hi_i, lo_i};
    dvd_neg   = sgn_i & hi_i[DW-1];
    dvs_neg   = sgn_i & dvs_i[DW-1];
    dvd_mag_o = dvd_neg ? -dvd : dvd;
    dvs_mag_o = dvs_neg ? -dvs_i : dvs_i;
    neg_o     = dvd_neg ^ dvs_neg;
    zero_o    = (dvs_i == '0);
  end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   rem_i,
  input  logic [2*DW-1:0] quo_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [DW-1:0]   rem_o,
  output logic [2*DW-1:0] quo_o
);
  logic [DW:0] trial, diff;
  logic        fits;

  // restoring step: shift in next dividend bit, subtract if possible
  always_comb begin
    trial = {rem_i, quo_i[2*DW-1]};
    diff  = trial - {1'b0, dvs_i};
    fits  = (trial >= {1'b0, dvs_i});
    rem_o = fits ? diff[DW-1:0] : trial[DW-1:0];
    quo_o = {quo_i[2*DW-2:0], fits};
  end
endmodule

// File: rtl/sdiv_post.sv
module sdiv_post
  import sdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] quo_mag_i,
  input  logic            sgn_i,
  input  logic            neg_i,
  output logic [DW-1:0]   res_o,
  output sdiv_flags_t     flg_o
);
  localparam logic [DW-1:0] UMAX = '1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic hi_nz, sat;

  always_comb begin
    hi_nz = |quo_mag_i[2*DW-1:DW];
    if (!sgn_i) begin
      sat   = hi_nz;
      res_o = sat ? UMAX : quo_mag_i[DW-1:0];
    end else if (!neg_i) begin
      sat   = hi_nz | quo_mag_i[DW-1];
      res_o = sat ? SMAX : quo_mag_i[DW-1:0];
    end else begin
      sat   = hi_nz | (quo_mag_i[DW-1] & (|quo_mag_i[DW-2:0]));
      res_o = sat ? SMIN : -quo_mag_i[DW-1:0];
    end
    flg_o.z = (res_o == '0);
    flg_o.n = res_o[DW-1];
    flg_o.v = sat;
    flg_o.c = 1'b0;
  end

  // R4: unclamped signed result carries the expected sign
  always_comb begin
    a_r4_sign_match: assert (!sgn_i || sat || res_o == '0 || res_o[DW-1] == neg_i)
      else $error("a_r4_sign_match");
  end
endmodule

// File: rtl/sat_div64.sv
module sat_div64
  import sdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          dbz_o,
  output logic [DW-1:0] quot_o,
  output logic          flag_z_o,
  output logic          flag_n_o,
  output logic          flag_v_o,
  output logic          flag_c_o
);
  localparam int QW  = 2 * DW;
  localparam int NIT = QW;
  localparam int CW  = $clog2(NIT + 1);
  localparam logic [CW-1:0] LAST = CW'(NIT - 1);
  localparam logic [DW-1:0] UMAX = '1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  sdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hi_q, lo_q, dvs_q, dvsm_q, rem_q;
  logic [QW-1:0] quo_q;
  logic          sgn_q, neg_q, zero_q;
  sdiv_flags_t   flg_q;

  logic [QW-1:0] dvd_mag, quo_nx;
  logic [DW-1:0] dvs_mag, rem_nx, res;
  logic          neg_c, zero_c;
  sdiv_flags_t   flg_c;

  sdiv_prep #(.DW(DW)) u_prep (
    .hi_i(hi_q), .lo_i(lo_q), .dvs_i(dvs_q), .sgn_i(sgn_q),
    .dvd_mag_o(dvd_mag), .dvs_mag_o(dvs_mag), .neg_o(neg_c), .zero_o(zero_c)
  );

  sdiv_step #(.DW(DW)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dvsm_q),
    .rem_o(rem_nx), .quo_o(quo_nx)
  );

  sdiv_post #(.DW(DW)) u_post (
    .quo_mag_i(quo_q), .sgn_i(sgn_q), .neg_i(neg_q),
    .res_o(res), .flg_o(flg_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      dvs_q   <= '0;
      sgn_q   <= 1'b0;
      dvsm_q  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      quot_o  <= '0;
      flg_q   <= '0;
      done_o  <= 1'b0;
      dbz_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      dbz_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          hi_q    <= y_i;
          lo_q    <= op_a_i;
          dvs_q   <= op_b_i;
          sgn_q   <= signed_i;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          quo_q   <= dvd_mag;
          dvsm_q  <= dvs_mag;
          neg_q   <= neg_c;
          zero_q  <= zero_c;
          rem_q   <= '0;
          cnt_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          dbz_o   <= zero_q;
          if (!zero_q) begin
            quot_o <= res;
            flg_q  <= flg_c;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign flag_z_o = flg_q.z;
  assign flag_n_o = flg_q.n;
  assign flag_v_o = flg_q.v;
  assign flag_c_o = flg_q.c;

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  a_r2_dbz_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbz_o |-> done_o && $stable(quot_o));
  a_r6_ops_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dvs_q) && $stable(hi_q) && $stable(lo_q));
  a_r7_v_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !dbz_o && flag_v_o |-> quot_o == UMAX || quot_o == SMAX || quot_o == SMIN);
  a_r8_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !dbz_o |-> flag_z_o == (quot_o == '0) && flag_n_o == quot_o[DW-1]);
endmodule

// File: tb/sim_sat_div64.sv
`timescale 1ns/1ps
module sim_sat_div64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] y = '0, a = '0, b = '0;
  logic        busy, done, dbz, fz, fn, fv, fc;
  logic [31:0] quot;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  sat_div64 u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .y_i(y), .op_a_i(a), .op_b_i(b),
    .busy_o(busy), .done_o(done), .dbz_o(dbz), .quot_o(quot),
    .flag_z_o(fz), .flag_n_o(fn), .flag_v_o(fv), .flag_c_o(fc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // arithmetic reference from the requirements
  task automatic ref_div(input bit s, input logic [31:0] yy, aa, bb,
                         output logic [31:0] q, output bit v, output bit dz);
    logic [63:0] dvd, dm, qm;
    logic [31:0] bm;
    bit neg;
    dz = (bb == 0);
    dvd = {yy, aa};
    q = '0; v = 0;
    if (dz) return;
    if (!s) begin
      qm = dvd / {32'd0, bb};
      v  = (qm[63:32] != 0);
      q  = v ? 32'hFFFFFFFF : qm[31:0];
    end else begin
      dm  = yy[31] ? -dvd : dvd;
      bm  = bb[31] ? -bb : bb;
      neg = yy[31] ^ bb[31];
      qm  = dm / {32'd0, bm};
      if (!neg) begin
        v = (qm > 64'h7FFFFFFF);
        q = v ? 32'h7FFFFFFF : qm[31:0];
      end else begin
        v = (qm > 64'h80000000);
        q = v ? 32'h80000000 : -qm[31:0];
      end
    end
  endtask

  // cycle model
  bit          mbusy, mdone, mdbz, mz, mn, mv;
  logic [31:0] mq;
  int          mcnt;
  logic [31:0] pq;
  bit          pv, pdz;
  string       mtag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy <= 0; mdone <= 0; mdbz <= 0; mcnt <= 0;
      mq <= '0; mz <= 0; mn <= 0; mv <= 0;
    end else begin
      mdone <= 0;
      mdbz  <= 0;
      if (mbusy) begin
        if (mcnt == 65) begin
          mbusy <= 0;
          mdone <= 1;
          mdbz  <= pdz;
          if (!pdz) begin
            mq <= pq; mz <= (pq == 0); mn <= pq[31]; mv <= pv;
          end
        end else mcnt <= mcnt + 1;
      end else if (start) begin
        logic [31:0] tq; bit tv, tdz;
        ref_div(sgn, y, a, b, tq, tv, tdz);
        pq <= tq; pv <= tv; pdz <= tdz;
        mtag <= tdz ? "R2" : (tv ? (sgn ? "R4" : "R3") : (sgn ? "R4" : "R1"));
        mbusy <= 1;
        mcnt  <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(busy == mbusy, "R5 busy", {31'd0, busy}, {31'd0, mbusy});
      chk(done == mdone, "R5 done", {31'd0, done}, {31'd0, mdone});
      chk(dbz == mdbz, "R2 dbz", {31'd0, dbz}, {31'd0, mdbz});
      chk(quot == mq, {mtag, " quot"}, quot, mq);
      chk(fv == mv, "R7 V", {31'd0, fv}, {31'd0, mv});
      chk(fc == 1'b0, "R7 C", {31'd0, fc}, 32'd0);
      chk(fz == mz, "R8 Z", {31'd0, fz}, {31'd0, mz});
      chk(fn == mn, "R8 N", {31'd0, fn}, {31'd0, mn});
    end
  end

  // call at a negedge; returns at the negedge of the done cycle
  task automatic run(input bit s, input logic [31:0] yy, aa, bb);
    sgn = s; y = yy; a = aa; b = bb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!mdone) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({busy, done, dbz, fz, fn, fv, fc} == 7'd0, "R9 ctl", {25'd0, busy, done, dbz, fz, fn, fv, fc}, 32'd0);
    chk(quot == 32'd0, "R9 quot", quot, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(0, 32'd0, 32'd100, 32'd7);                 // R1 -> 14
    chk(quot == 32'd14, "R1", quot, 32'd14);
    run(0, 32'd1, 32'd0, 32'd2);                   // R1 -> 0x80000000
    run(0, 32'd5, 32'd0, 32'd5);                   // R3 clamp
    chk(quot == 32'hFFFFFFFF && fv, "R3", quot, 32'hFFFFFFFF);
    run(0, 32'd4, 32'hFFFFFFFF, 32'd5);            // R3 boundary, no clamp
    chk(quot == 32'hFFFFFFFF && !fv, "R3 edge", {31'd0, fv}, 32'd0);
    run(0, 32'd0, 32'd3, 32'd7);                   // R8 zero result
    chk(fz == 1'b1, "R8", {31'd0, fz}, 32'd1);
    run(1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'd2);     // R4 -7/2 = -3
    chk(quot == 32'hFFFFFFFD, "R4 trunc", quot, 32'hFFFFFFFD);
    run(1, 32'd0, 32'd7, 32'hFFFFFFFE);            // 7/-2
    run(1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'hFFFFFFFE);
    run(1, 32'd0, 32'h80000000, 32'd1);            // +2^31 clamps
    chk(quot == 32'h7FFFFFFF && fv, "R4 pos", quot, 32'h7FFFFFFF);
    run(1, 32'hFFFFFFFF, 32'h80000000, 32'd1);     // -2^31 exact
    chk(quot == 32'h80000000 && !fv, "R4 min", quot, 32'h80000000);
    run(1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'd1);     // -2^31-1 clamps
    chk(quot == 32'h80000000 && fv, "R4 neg", quot, 32'h80000000);
    run(1, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF);
    run(1, 32'h80000000, 32'd0, 32'hFFFFFFFF);
    run(1, 32'h80000000, 32'd0, 32'd1);
    run(0, 32'd9, 32'd9, 32'd0);                   // R2
    chk(dbz == 1'b1, "R2", {31'd0, dbz}, 32'd1);
    run(1, 32'hFFFFFFFF, 32'hFFFFFFF0, 32'd0);

    // R6: restart and operand change during busy are ignored
    sgn = 0; y = 32'd0; a = 32'd1000; b = 32'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    y = 32'd7; a = 32'd5; b = 32'd0; sgn = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = 32'd3;
    while (!mdone) @(negedge clk);
    chk(quot == 32'd100 && !dbz, "R6", quot, 32'd100);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] ry, rb;
      ry = $urandom;
      rb = $urandom;
      if (i % 4 == 0) ry = ry >> 20;
      if (i % 7 == 0) rb = 32'd0;
      run(i[0], ry, $urandom, rb);
    end
    repeat (3) @(negedge clk);

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule